// File: doc/BRIEF.md
# Two-Stage Converter Power Sequencing Supervisor

This block is the digital sequencer for an offline supply built from two power stages. The first is a boost pre-regulator and the second a resonant half-bridge stage that draws from the pre-regulator's bulk capacitor. The analog parts of the controller reduce their state to digital flags: comparators, error amplifiers, the oscillator and the drivers. The supervisor turns those flags into three outputs: an enable for each stage and an active-low power-good line toward the secondary side.

Start-up is staged. A low level on the remote-enable input starts the pre-regulator. The supervisor then waits for the first drive pulse and for the output-low-detect flag to clear. After a programmable delay in milliseconds it starts the resonant stage. Shutdown is asymmetric. If the pre-regulator stops on its own fault, power-good drops at once and the resonant stage keeps running for a short drain delay. A grand reset stops everything at once. The grand reset comes from remote disable, supply undervoltage or over-temperature. A latched fault, or a control voltage that stays out of its window for too long, parks the block in a lockout state. Only a grand reset clears it.

Every delay counts pulses of a millisecond tick taken from the system clock by a divider. All flag inputs are asynchronous and pass through two-flop synchronisers.

Top module: `pwr_seq_supervisor`

## Requirements
- R1: After reset the outputs are pre_en=0, res_en=0 and pg_out_n=1, and state_oh reads 7'b0000001. The state_oh bits are: bit0 idle, bit1 pre-regulator starting, bit2 pre-regulator settling, bit3 second-stage delay, bit4 run, bit5 second-stage drain, bit6 lockout.
- R2: While remote_en_n is high, the block goes to idle with both enables low, from any state including lockout.
- R3: When remote_en_n goes low in idle, with no fault present, the block enters the starting state (bit1) with pre_en=1 and res_en=0.
- R4: The starting state moves to settling (bit2) only after a pre_drive_pulse is seen. Settling moves to the second-stage delay (bit3) only once vout_low is low.
- R5: The second-stage delay lasts DLY2_MS ticks (default 20; meant to be 10 to 30). Counted in clock edges from entry into bit3 to entry into run (bit4), it lies between (DLY2_MS-1)*CLK_PER_MS+2 and DLY2_MS*CLK_PER_MS+1. In run, res_en=1 and pre_en=1.
- R6: In run, pg_out_n is low exactly when bulk_good is high. A loss of bulk_good raises pg_out_n but leaves both enables on.
- R7: pre_fault in run enters drain (bit5) with pre_en=0, pg_out_n=1 and res_en still 1. res_en drops and the block enters idle DRAIN_MS ticks later, inside the window of R5 with DRAIN_MS in place of DLY2_MS.
- R8: If ctrl_out_of_window stays high for ABN_MS ticks while the pre-regulator is enabled, the block enters lockout (bit6) with all enables off. Any interruption of the flag restarts the count.
- R9: fault_latch enters lockout, and lockout holds until a grand reset.
- R10: supply_uv or over_temp forces idle at once with res_en=0 and no drain delay. After it clears, with remote enabled, start-up begins again.
- R11: pre_fault before run (states bit1 to bit3) returns the block straight to idle.
- R12: Every input takes effect three clock edges after it changes: two synchroniser flops, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| remote_en_n | input | 1 | Remote enable, low = run |
| vout_low | input | 1 | Pre-regulator output-low-detect flag |
| pre_drive_pulse | input | 1 | Pre-regulator issued a drive pulse |
| ctrl_out_of_window | input | 1 | Control voltage outside its allowed window |
| bulk_good | input | 1 | Bulk voltage above the power-good trip level |
| supply_uv | input | 1 | Supply undervoltage |
| over_temp | input | 1 | Over-temperature |
| fault_latch | input | 1 | Fault that must latch the block off |
| pre_fault | input | 1 | Auto-recovering pre-regulator fault |
| pre_en | output | 1 | Pre-regulator stage enable |
| res_en | output | 1 | Resonant stage enable |
| pg_out_n | output | 1 | Power-good, active low |
| state_oh | output | 7 | One-hot sequencer state |

## Verification
The bench sweeps the start-up at every phase of the millisecond tick against the second-stage delay. This catches an off-by-one in the timer compare, which would start the resonant stage a tick early or late, and a timer that keeps a stale count between arming intervals. It checks that a pre-regulator fault in run keeps the resonant stage on for exactly the drain window. A design that drops both stages together, or never drops the second, fails there. It also breaks the out-of-window condition partway through, to catch a timer that fails to restart. Finally it checks that lockout survives everything but a grand reset, and that undervoltage and over-temperature skip the drain delay.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_PRE_START    = 3'd1,
    ST_PRE_SETTLE   = 3'd2,
    ST_STAGE2_WAIT  = 3'd3,
    ST_RUN          = 3'd4,
    ST_STAGE2_DRAIN = 3'd5,
    ST_LOCKOUT      = 3'd6
  } pseq_state_e;

  localparam int NUM_STATES = 7;

  // Positions of the flags in the synchroniser vector
  localparam int FL_REMOTE_N = 0;
  localparam int FL_VOUT_LOW = 1;
  localparam int FL_PULSE    = 2;
  localparam int FL_WINDOW   = 3;
  localparam int FL_BULK     = 4;
  localparam int FL_UV       = 5;
  localparam int FL_OTP      = 6;
  localparam int FL_LATCH    = 7;
  localparam int FL_PFAULT   = 8;
  localparam int NUM_FLAGS   = 9;

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
  parameter int          WIDTH   = 4,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RST_VAL;
          else        chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RST_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pseq_tick.sv
module pseq_tick #(
  parameter int CLK_PER_MS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int CW = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R5: tick is a single-cycle pulse
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int LIMIT_MS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic tick_i,
  output logic done_o
);

  localparam int TW = $clog2(LIMIT_MS + 1);
  localparam logic [TW-1:0] LIMIT = TW'(LIMIT_MS);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!arm_i)
      cnt_d = '0;
    else if (tick_i && (cnt_q != LIMIT))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = arm_i && (cnt_q == LIMIT);

  // R8: count never passes its limit
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R8: losing the arming condition restarts the count
  a_r8_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwr_seq_supervisor.sv
module pwr_seq_supervisor
  import pseq_pkg::*;
#(
  parameter int CLK_PER_MS = 125000,
  parameter int DLY2_MS    = 20,
  parameter int DRAIN_MS   = 5,
  parameter int ABN_MS     = 1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  remote_en_n,
  input  logic                  vout_low,
  input  logic                  pre_drive_pulse,
  input  logic                  ctrl_out_of_window,
  input  logic                  bulk_good,
  input  logic                  supply_uv,
  input  logic                  over_temp,
  input  logic                  fault_latch,
  input  logic                  pre_fault,
  output logic                  pre_en,
  output logic                  res_en,
  output logic                  pg_out_n,
  output logic [NUM_STATES-1:0] state_oh
);

  localparam logic [NUM_FLAGS-1:0] FLAG_RST =
    NUM_FLAGS'((1 << FL_REMOTE_N) | (1 << FL_VOUT_LOW));

  logic [NUM_FLAGS-1:0] raw_flags, sflags;
  logic tick;
  logic grand_rst, pre_active;
  logic dly_done, drain_done, abn_done;
  logic arm_dly, arm_drain, arm_abn;

  pseq_state_e state_q, state_d;
  logic pre_en_q, res_en_q, pg_n_q;

  assign raw_flags[FL_REMOTE_N] = remote_en_n;
  assign raw_flags[FL_VOUT_LOW] = vout_low;
  assign raw_flags[FL_PULSE]    = pre_drive_pulse;
  assign raw_flags[FL_WINDOW]   = ctrl_out_of_window;
  assign raw_flags[FL_BULK]     = bulk_good;
  assign raw_flags[FL_UV]       = supply_uv;
  assign raw_flags[FL_OTP]      = over_temp;
  assign raw_flags[FL_LATCH]    = fault_latch;
  assign raw_flags[FL_PFAULT]   = pre_fault;

  pseq_sync #(.WIDTH(NUM_FLAGS), .STAGES(2), .RST_VAL(FLAG_RST)) i_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw_flags),
    .sync_o  (sflags)
  );

  pseq_tick #(.CLK_PER_MS(CLK_PER_MS)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  assign grand_rst  = sflags[FL_REMOTE_N] | sflags[FL_UV] | sflags[FL_OTP];
  assign pre_active = (state_q == ST_PRE_START) || (state_q == ST_PRE_SETTLE) ||
                      (state_q == ST_STAGE2_WAIT) || (state_q == ST_RUN);

  assign arm_dly   = (state_q == ST_STAGE2_WAIT);
  assign arm_drain = (state_q == ST_STAGE2_DRAIN);
  assign arm_abn   = pre_active && sflags[FL_WINDOW];

  pseq_timer #(.LIMIT_MS(DLY2_MS)) i_tmr_dly (
    .clk (clk), .rst_n (rst_n), .arm_i (arm_dly), .tick_i (tick), .done_o (dly_done)
  );

  pseq_timer #(.LIMIT_MS(DRAIN_MS)) i_tmr_drain (
    .clk (clk), .rst_n (rst_n), .arm_i (arm_drain), .tick_i (tick), .done_o (drain_done)
  );

  pseq_timer #(.LIMIT_MS(ABN_MS)) i_tmr_abn (
    .clk (clk), .rst_n (rst_n), .arm_i (arm_abn), .tick_i (tick), .done_o (abn_done)
  );

  // Next-state decode
  always_comb begin
    state_d = state_q;
    if (grand_rst) begin
      state_d = ST_IDLE;
    end else if (sflags[FL_LATCH] || abn_done) begin
      state_d = ST_LOCKOUT;
    end else begin
      unique case (state_q)
        ST_IDLE:
          if (!sflags[FL_PFAULT]) state_d = ST_PRE_START;
        ST_PRE_START:
          if (sflags[FL_PFAULT])     state_d = ST_IDLE;
          else if (sflags[FL_PULSE]) state_d = ST_PRE_SETTLE;
        ST_PRE_SETTLE:
          if (sflags[FL_PFAULT])         state_d = ST_IDLE;
          else if (!sflags[FL_VOUT_LOW]) state_d = ST_STAGE2_WAIT;
        ST_STAGE2_WAIT:
          if (sflags[FL_PFAULT]) state_d = ST_IDLE;
          else if (dly_done)     state_d = ST_RUN;
        ST_RUN:
          if (sflags[FL_PFAULT]) state_d = ST_STAGE2_DRAIN;
        ST_STAGE2_DRAIN:
          if (drain_done) state_d = ST_IDLE;
        ST_LOCKOUT:
          state_d = ST_LOCKOUT;
        default:
          state_d = ST_IDLE;
      endcase
    end
  end

  // State and registered output decode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pre_en_q <= 1'b0;
      res_en_q <= 1'b0;
      pg_n_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      pre_en_q <= (state_d == ST_PRE_START) || (state_d == ST_PRE_SETTLE) ||
                  (state_d == ST_STAGE2_WAIT) || (state_d == ST_RUN);
      res_en_q <= (state_d == ST_RUN) || (state_d == ST_STAGE2_DRAIN);
      pg_n_q   <= !((state_d == ST_RUN) && sflags[FL_BULK]);
    end
  end

  assign pre_en   = pre_en_q;
  assign res_en   = res_en_q;
  assign pg_out_n = pg_n_q;
  assign state_oh = NUM_STATES'(1) << state_q;

  // R2: synchronised remote disable empties both stages next edge
  a_r2_remote_off: assert property (@(posedge clk) disable iff (!rst_n)
    sflags[FL_REMOTE_N] |=> (state_q == ST_IDLE) && !pre_en_q && !res_en_q);

  // R5: resonant stage only ever starts out of the delay state
  a_r5_start_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_en_q) |-> ($past(state_q) == ST_STAGE2_WAIT));

  // R6: power-good only asserted with both stages on
  a_r6_pg_with_stages: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_n_q |-> (pre_en_q && res_en_q));

  // R9: lockout holds without a grand reset
  a_r9_lockout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCKOUT) && !grand_rst |=> (state_q == ST_LOCKOUT));

  // R11: pre-regulator fault before run goes straight to idle
  a_r11_early_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PRE_START) || (state_q == ST_PRE_SETTLE) ||
     (state_q == ST_STAGE2_WAIT)) && sflags[FL_PFAULT] && !grand_rst &&
    !sflags[FL_LATCH] && !abn_done |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_pwr_seq_supervisor.sv
`timescale 1ns/1ps
module test_pwr_seq_supervisor;

  localparam int P   = 8;
  localparam int L   = 20;
  localparam int S   = 5;
  localparam int A   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic remote_en_n = 1'b1, vout_low = 1'b1, pre_drive_pulse = 1'b0;
  logic ctrl_out_of_window = 1'b0, bulk_good = 1'b0, supply_uv = 1'b0;
  logic over_temp = 1'b0, fault_latch = 1'b0, pre_fault = 1'b0;
  logic pre_en, res_en, pg_out_n;
  logic [6:0] state_oh;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pwr_seq_supervisor #(.CLK_PER_MS(P), .DLY2_MS(L), .DRAIN_MS(S), .ABN_MS(A)) i_pwr_seq_supervisor (
    .clk (clk), .rst_n (rst_n), .remote_en_n (remote_en_n), .vout_low (vout_low),
    .pre_drive_pulse (pre_drive_pulse), .ctrl_out_of_window (ctrl_out_of_window),
    .bulk_good (bulk_good), .supply_uv (supply_uv), .over_temp (over_temp),
    .fault_latch (fault_latch), .pre_fault (pre_fault),
    .pre_en (pre_en), .res_en (res_en), .pg_out_n (pg_out_n), .state_oh (state_oh)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts edges until state bit idx is set
  task automatic wait_bit(input int idx, input int maxc, output int n);
    n = 0;
    while (!state_oh[idx] && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic bring_up(input int extra, input bit latency_chk);
    int n;
    @(negedge clk);
    remote_en_n = 1'b0;
    if (latency_chk) begin
      cycles(2);
      chk("R12 pre_en after two edges", pre_en, 0);
      cycles(1);
      chk("R12 pre_en after three edges", pre_en, 1);
      chk("R3 starting state", state_oh, 7'b0000010);
      chk("R3 res_en off", res_en, 0);
    end else begin
      cycles(3);
    end
    cycles(extra + 4);
    chk("R4 no pulse stays starting", state_oh, 7'b0000010);
    pre_drive_pulse = 1'b1;
    cycles(1);
    pre_drive_pulse = 1'b0;
    cycles(5);
    chk("R4 settling while output low", state_oh, 7'b0000100);
    vout_low = 1'b0;
    wait_bit(3, 10, n);
    chk("R4 enters delay", state_oh, 7'b0001000);
    wait_bit(4, L * P + 20, n);
    chk_rng("R5 delay window", n, (L - 1) * P + 2, L * P + 1);
    chk("R5 res_en in run", res_en, 1);
    chk("R5 pre_en in run", pre_en, 1);
  endtask

  task automatic go_down();
    remote_en_n = 1'b1;
    cycles(3);
    chk("R2 idle after remote off", state_oh, 7'b0000001);
    chk("R2 enables off", {pre_en, res_en}, 0);
    vout_low = 1'b1;
    bulk_good = 1'b0;
    cycles(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    chk("R1 reset state", state_oh, 7'b0000001);
    chk("R1 pre_en", pre_en, 0);
    chk("R1 res_en", res_en, 0);
    chk("R1 pg_out_n", pg_out_n, 1);

    // R5 sweep over every tick phase
    for (int ph = 0; ph < P; ph++) begin
      bring_up(ph, ph == 0);
      go_down();
    end

    // R6 power-good follows bulk in run
    bring_up(1, 1'b0);
    bulk_good = 1'b1;
    cycles(3);
    chk("R6 pg low with bulk good", pg_out_n, 0);
    bulk_good = 1'b0;
    cycles(3);
    chk("R6 pg high on bulk loss", pg_out_n, 1);
    chk("R6 stages stay on", {pre_en, res_en}, 3);
    bulk_good = 1'b1;
    cycles(3);

    // R7 drain on pre-regulator fault
    pre_fault = 1'b1;
    wait_bit(5, 10, n);
    chk("R7 drain state", state_oh, 7'b0100000);
    chk("R7 pre_en off", pre_en, 0);
    chk("R7 pg high", pg_out_n, 1);
    chk("R7 res_en held", res_en, 1);
    n = 0;
    while (res_en && n < S * P + 20) begin
      @(negedge clk);
      n++;
    end
    chk_rng("R7 drain window", n, (S - 1) * P + 2, S * P + 1);
    chk("R7 idle after drain", state_oh, 7'b0000001);
    cycles(5);
    chk("R7 idle while fault", state_oh, 7'b0000001);
    pre_fault = 1'b0;
    cycles(4);
    chk("R7 restart after fault", state_oh, 7'b0000010);
    go_down();

    // R11 early pre-regulator fault
    remote_en_n = 1'b0;
    cycles(4);
    pre_drive_pulse = 1'b1;
    cycles(1);
    pre_drive_pulse = 1'b0;
    cycles(5);
    pre_fault = 1'b1;
    cycles(3);
    chk("R11 idle on early fault", state_oh, 7'b0000001);
    chk("R11 pre_en off", pre_en, 0);
    pre_fault = 1'b0;
    go_down();

    // R8 out-of-window with interruption
    remote_en_n = 1'b0;
    cycles(4);
    ctrl_out_of_window = 1'b1;
    cycles(20 * P);
    ctrl_out_of_window = 1'b0;
    cycles(4);
    chk("R8 no lockout after break", state_oh, 7'b0000010);
    ctrl_out_of_window = 1'b1;
    wait_bit(6, A * P + 20, n);
    chk_rng("R8 abnormal window", n, (A - 1) * P + 4, A * P + 3);
    chk("R8 lockout outputs", {pre_en, res_en, pg_out_n}, 1);
    ctrl_out_of_window = 1'b0;

    // R9 lockout holds
    cycles(100);
    chk("R9 lockout held", state_oh, 7'b1000000);

    // R10 undervoltage clears, then restart
    supply_uv = 1'b1;
    cycles(3);
    chk("R10 idle on undervoltage", state_oh, 7'b0000001);
    supply_uv = 1'b0;
    cycles(4);
    chk("R10 restart after uv", state_oh, 7'b0000010);

    // R9 latch fault, cleared by remote off (R2)
    fault_latch = 1'b1;
    cycles(1);
    fault_latch = 1'b0;
    cycles(3);
    chk("R9 latch fault lockout", state_oh, 7'b1000000);
    cycles(30);
    chk("R9 lockout after pulse", state_oh, 7'b1000000);
    go_down();

    // R10 over-temperature in run: no drain
    bring_up(3, 1'b0);
    over_temp = 1'b1;
    cycles(3);
    chk("R10 idle on over-temp", state_oh, 7'b0000001);
    chk("R10 res_en off at once", res_en, 0);
    over_temp = 1'b0;
    go_down();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule